// File: doc/BRIEF.md
# Wake Pattern Match Checker

This block watches received frames while the chip is in a low-power wake state. It compares the bytes of each frame against up to nine stored wake patterns and records which patterns were found. The pattern bytes come from a preloaded store. Each pattern word carries three things: a data byte, a per-byte don't-care mask bit and an end-of-pattern bit. The block drives the byte position and a per-group read strobe, and the store answers in the same cycle on a flat nine-word bus.

A small controller steps through four states: idle, initialise, compare and report. When power-managed wake is enabled, the controller leaves idle and spends one initialise cycle. That cycle rewinds the pattern store's read state and clears the match register. While checking is active, receive traffic goes only to the checker and is not forwarded.

At 10/100 speed a byte arrives at most once every four cycles. One comparator set of three lanes is then shared: it serves patterns 0–2, 3–5 and 6–8 in the first three cycles of the slot and rests in the fourth. At gigabit speed, bytes may arrive every cycle. All three groups are then fetched and compared together, three words per group, in the cycle after the byte is taken.

Top module: `wol_pattern_checker`

## Requirements
- R1: After reset the controller is idle, `match_q` is all zero and `wake` is low.
- R2: While idle, the controller stays idle whatever arrives until `pm_en` is high. `rx_fwd_valid` follows `rx_valid` and `rx_fwd_data` follows `rx_data`.
- R3: When `pm_en` rises in idle, the next cycle is a single initialise cycle. In that cycle `pat_rewind` is high and `match_q` is cleared, before any comparison. Outside idle, `rx_fwd_valid` stays low.
- R4: At 10/100 speed (`gig_mode`=0), a byte taken in cycle t produces `pat_grp_rd` = 001, 010 and 100 in cycles t+1, t+2 and t+3, and 000 in t+4. Bit g selects patterns 3g to 3g+2.
- R5: At gigabit speed (`gig_mode`=1), a byte taken in cycle t produces `pat_grp_rd` = 111 in cycle t+1 only. A new byte may be taken every cycle.
- R6: Pattern p occupies bits [10p+9:10p] of `pat_word`. Bit 9 of a word is the end-of-pattern flag, bit 8 is the mask and bits 7:0 are the data. `pat_pos` counts byte positions from 0 at the start-of-frame byte.
- R7: Each pattern's running flag is set by the start-of-frame byte. An unmasked mismatching byte clears it, and a later equal byte does not set it again. A masked byte always passes.
- R8: Bit p of `match_q` sets when the word flagged as pattern p's end is compared with the running flag still set. If the frame ends first, the bit stays clear.
- R9: Bytes received outside a frame (no start-of-frame byte since the last end) change no match bit.
- R10: When a frame ends with any match bit set, the controller enters report. There it neither compares nor forwards received bytes, and `wake` equals the OR of `match_q`.
- R11: Match bits and `wake` stay set until `match_clr` or an initialise cycle. `match_clr` clears all bits, and report then returns to compare.
- R12: `pm_en` low returns the controller to idle on the next cycle and leaves `match_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pm_en | input | 1 | Power-managed wake enable |
| gig_mode | input | 1 | 1 = gigabit timing, 0 = 10/100 timing |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | DATA_W | Receive byte |
| rx_fwd_valid | output | 1 | Byte valid toward the normal receive path |
| rx_fwd_data | output | DATA_W | Byte toward the normal receive path |
| pat_pos | output | LEN_W | Pattern byte position being read |
| pat_grp_rd | output | NUM_GRP | Per-group pattern read strobe |
| pat_rewind | output | 1 | Rewind of the pattern store read state |
| pat_word | input | NUM_PAT*WORD_W | Pattern words at `pat_pos`, one per pattern |
| match_clr | input | 1 | Clear the match register |
| match_q | output | NUM_PAT | Match register, one bit per pattern |
| wake | output | 1 | Wake request, high while any match bit is set |

## Verification
The properties take `gig_mode` to be steady for the length of a frame. At 10/100 speed they also take receive bytes to be at least four cycles apart, and they take the pattern store to answer in the same cycle it is addressed. The stimulus keeps to all three conditions. It changes the speed only between frames and drives each 10/100 byte exactly four cycles after the previous one. Its pattern model returns the addressed row combinationally. It sends frames only after a clear has returned the controller to compare, except in the test that exercises the report state on purpose.

// File: rtl/wol_pkg.sv
package wol_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_INIT = 2'd1,
      ST_CMP  = 2'd2,
      ST_RPT  = 2'd3
   } wol_state_t;

   localparam int SLOT_CYC = 4;
endpackage

// File: rtl/wol_slot_seq.sv
module wol_slot_seq #(
   parameter int NUM_GRP  = 3,
   parameter int SLOT_CYC = 4,
   localparam int PH_W    = $clog2(SLOT_CYC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill,
   input  logic               accept,
   input  logic               gig,
   output logic [NUM_GRP-1:0] grp_en,
   output logic               byte_done
);
   logic            act_q;
   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         phase_q <= '0;
      end else if (kill) begin
         act_q   <= 1'b0;
         phase_q <= '0;
      end else if (accept) begin
         act_q   <= 1'b1;
         phase_q <= '0;
      end else if (act_q) begin
         if (gig || phase_q == PH_W'(SLOT_CYC - 1)) begin
            act_q   <= 1'b0;
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_en
      assign grp_en[g] = act_q & (gig | (phase_q == PH_W'(g)));
   end

   assign byte_done = act_q & (gig | (phase_q == PH_W'(NUM_GRP - 1)));
endmodule

// File: rtl/wol_cmp_lane.sv
module wol_cmp_lane #(
   parameter int GRP    = 3,
   parameter int DATA_W = 8,
   localparam int WORD_W = DATA_W + 2
) (
   input  logic [DATA_W-1:0]     byte_i,
   input  logic [GRP*WORD_W-1:0] words_i,
   output logic [GRP-1:0]        hit_o,
   output logic [GRP-1:0]        last_o
);
   for (genvar k = 0; k < GRP; k++) begin : g_lane
      logic [WORD_W-1:0] w;
      assign w         = words_i[k*WORD_W +: WORD_W];
      assign hit_o[k]  = w[DATA_W] | (w[DATA_W-1:0] == byte_i);
      assign last_o[k] = w[DATA_W+1];
   end
endmodule

// File: rtl/wol_match_track.sv
module wol_match_track #(
   parameter int NUM_PAT = 9,
   parameter int GRP     = 3,
   localparam int NUM_GRP = NUM_PAT / GRP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init,
   input  logic               clr,
   input  logic               sof_set,
   input  logic               frame_end,
   input  logic               pos_max,
   input  logic [NUM_GRP-1:0] grp_en,
   input  logic [NUM_PAT-1:0] hit,
   input  logic [NUM_PAT-1:0] last,
   output logic [NUM_PAT-1:0] match_q,
   output logic               frame_done_q
);
   logic [NUM_PAT-1:0] run_q;

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      logic cmp;
      assign cmp = grp_en[p / GRP] & run_q[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q[p]   <= 1'b0;
            match_q[p] <= 1'b0;
         end else begin
            if (init)
               run_q[p] <= 1'b0;
            else if (sof_set)
               run_q[p] <= 1'b1;
            else if (cmp & (~hit[p] | last[p] | pos_max))
               run_q[p] <= 1'b0;
            else if (frame_end)
               run_q[p] <= 1'b0;

            if (init | clr)
               match_q[p] <= 1'b0;
            else if (cmp & hit[p] & last[p])
               match_q[p] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_done_q <= 1'b0;
      else        frame_done_q <= frame_end & ~init;
   end
endmodule

// File: rtl/wol_pattern_checker.sv
module wol_pattern_checker #(
   parameter int DATA_W  = 8,
   parameter int NUM_PAT = 9,
   parameter int GRP     = 3,
   parameter int MAX_LEN = 16,
   parameter bit GIG_EN  = 1'b1,
   localparam int WORD_W  = DATA_W + 2,
   localparam int NUM_GRP = NUM_PAT / GRP,
   localparam int LEN_W   = $clog2(MAX_LEN)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pm_en,
   input  logic                      gig_mode,
   input  logic                      rx_valid,
   input  logic                      rx_sof,
   input  logic                      rx_eof,
   input  logic [DATA_W-1:0]         rx_data,
   output logic                      rx_fwd_valid,
   output logic [DATA_W-1:0]         rx_fwd_data,
   output logic [LEN_W-1:0]          pat_pos,
   output logic [NUM_GRP-1:0]        pat_grp_rd,
   output logic                      pat_rewind,
   input  logic [NUM_PAT*WORD_W-1:0] pat_word,
   input  logic                      match_clr,
   output logic [NUM_PAT-1:0]        match_q,
   output logic                      wake
);
   import wol_pkg::*;

   localparam int GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

   if (NUM_PAT % GRP != 0 || NUM_GRP >= SLOT_CYC || MAX_LEN < 2) begin : g_bad_cfg
      initial $error("wol_pattern_checker: unsupported parameter set");
   end

   wol_state_t          st_q, st_nx;
   logic                accept, gig, byte_done, frame_done_q, pos_max;
   logic [NUM_GRP-1:0]  seq_en, grp_en;
   logic [DATA_W-1:0]   hold_q;
   logic                hold_eof_q;
   logic [LEN_W-1:0]    pos_q;
   logic [NUM_PAT-1:0]  hit_v, last_v;

   // speed variant
   if (GIG_EN) begin : g_gig
      assign gig = gig_mode;
   end else begin : g_slow_only
      assign gig = 1'b0;
   end

   // control state machine
   always_comb begin
      st_nx = st_q;
      unique case (st_q)
         ST_IDLE: if (pm_en) st_nx = ST_INIT;
         ST_INIT: st_nx = ST_CMP;
         ST_CMP:  if (frame_done_q && (|match_q) && !match_clr) st_nx = ST_RPT;
         ST_RPT:  if (match_clr) st_nx = ST_CMP;
         default: st_nx = ST_IDLE;
      endcase
      if (!pm_en) st_nx = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nx;
   end

   assign accept     = (st_q == ST_CMP) & rx_valid;
   assign pat_rewind = (st_q == ST_INIT);

   // receive capture and byte position
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         hold_eof_q <= 1'b0;
         pos_q      <= '0;
      end else if (pat_rewind) begin
         hold_eof_q <= 1'b0;
         pos_q      <= '0;
      end else if (accept) begin
         hold_q     <= rx_data;
         hold_eof_q <= rx_eof;
         if (rx_sof)
            pos_q <= '0;
         else if (pos_q != LEN_W'(MAX_LEN - 1))
            pos_q <= pos_q + 1'b1;
      end
   end

   assign pos_max = (pos_q == LEN_W'(MAX_LEN - 1));
   assign pat_pos = pos_q;

   wol_slot_seq #(
      .NUM_GRP (NUM_GRP),
      .SLOT_CYC(SLOT_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (st_q != ST_CMP),
      .accept   (accept),
      .gig      (gig),
      .grp_en   (seq_en),
      .byte_done(byte_done)
   );

   assign grp_en     = seq_en & {NUM_GRP{st_q == ST_CMP}};
   assign pat_grp_rd = grp_en;

   // comparator variant: one lane set per group, or one shared set
   if (GIG_EN) begin : g_par_lanes
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         wol_cmp_lane #(.GRP(GRP), .DATA_W(DATA_W)) u_lane (
            .byte_i (hold_q),
            .words_i(pat_word[g*GRP*WORD_W +: GRP*WORD_W]),
            .hit_o  (hit_v[g*GRP +: GRP]),
            .last_o (last_v[g*GRP +: GRP])
         );
      end
   end else begin : g_shared_lane
      logic [GSEL_W-1:0]     sel;
      logic [GRP-1:0]        l_hit, l_last;
      logic [GRP*WORD_W-1:0] l_words;

      always_comb begin
         sel = '0;
         for (int g = 0; g < NUM_GRP; g++)
            if (grp_en[g]) sel = GSEL_W'(g);
      end

      assign l_words = pat_word[sel*GRP*WORD_W +: GRP*WORD_W];

      wol_cmp_lane #(.GRP(GRP), .DATA_W(DATA_W)) u_lane (
         .byte_i (hold_q),
         .words_i(l_words),
         .hit_o  (l_hit),
         .last_o (l_last)
      );

      for (genvar g = 0; g < NUM_GRP; g++) begin : g_fan
         assign hit_v[g*GRP +: GRP]  = l_hit;
         assign last_v[g*GRP +: GRP] = l_last;
      end
   end

   wol_match_track #(
      .NUM_PAT(NUM_PAT),
      .GRP    (GRP)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .init        (pat_rewind),
      .clr         (match_clr),
      .sof_set     (accept & rx_sof),
      .frame_end   (byte_done & hold_eof_q & (st_q == ST_CMP)),
      .pos_max     (pos_max),
      .grp_en      (grp_en),
      .hit         (hit_v),
      .last        (last_v),
      .match_q     (match_q),
      .frame_done_q(frame_done_q)
   );

   assign wake         = |match_q;
   assign rx_fwd_valid = rx_valid & (st_q == ST_IDLE);
   assign rx_fwd_data  = rx_data & {DATA_W{st_q == ST_IDLE}};
endmodule

// File: rtl/wol_pattern_checker_sva.sv
module wol_pattern_checker_sva #(
   parameter int NUM_PAT = 9,
   parameter int NUM_GRP = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pm_en,
   input logic               gig_mode,
   input logic               match_clr,
   input logic               rx_valid,
   input logic               rx_fwd_valid,
   input wol_pkg::wol_state_t st,
   input logic [NUM_GRP-1:0] pat_grp_rd,
   input logic [NUM_PAT-1:0] match_q,
   input logic               wake
);
   import wol_pkg::*;

   p_fwd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (rx_fwd_valid == rx_valid));

   p_no_fwd_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |-> !rx_fwd_valid);

   p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && pm_en) |=> (st == ST_INIT));

   p_init_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_INIT) |=> (match_q == '0));

   p_slow_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !gig_mode |-> $onehot0(pat_grp_rd));

   p_gig_parallel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gig_mode && (|pat_grp_rd)) |-> (&pat_grp_rd));

   p_rpt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RPT) |-> (pat_grp_rd == '0));

   p_wake_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake == (|match_q));

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_clr && st != ST_INIT) |=> ((match_q & $past(match_q)) == $past(match_q)));

   p_pm_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !pm_en |=> (st == ST_IDLE));
endmodule

bind wol_pattern_checker wol_pattern_checker_sva #(
   .NUM_PAT(NUM_PAT),
   .NUM_GRP(NUM_GRP)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .pm_en       (pm_en),
   .gig_mode    (gig_mode),
   .match_clr   (match_clr),
   .rx_valid    (rx_valid),
   .rx_fwd_valid(rx_fwd_valid),
   .st          (st_q),
   .pat_grp_rd  (pat_grp_rd),
   .match_q     (match_q),
   .wake        (wake)
);

// File: tb/wol_pattern_checker_test.sv
module wol_pattern_checker_test;
   localparam int DW = 8, NP = 9, NG = 3, ML = 16, WW = 10, LW = 4;

   logic          clk = 1'b0, rst_n = 1'b0, pm_en = 1'b0, gig_mode = 1'b0;
   logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, match_clr = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_fwd_valid, pat_rewind, wake;
   logic [DW-1:0] rx_fwd_data;
   logic [LW-1:0] pat_pos;
   logic [NG-1:0] pat_grp_rd;
   logic [NP*WW-1:0] pat_word;
   logic [NP-1:0] match_q;

   logic [WW-1:0] pmem [NP][ML];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wol_pattern_checker uut (
      .clk(clk), .rst_n(rst_n), .pm_en(pm_en), .gig_mode(gig_mode),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
      .rx_fwd_valid(rx_fwd_valid), .rx_fwd_data(rx_fwd_data),
      .pat_pos(pat_pos), .pat_grp_rd(pat_grp_rd), .pat_rewind(pat_rewind),
      .pat_word(pat_word), .match_clr(match_clr), .match_q(match_q), .wake(wake)
   );

   // pattern store model: answers the addressed row in the same cycle
   always_comb
      for (int p = 0; p < NP; p++) pat_word[p*WW +: WW] = pmem[p][pat_pos];

   typedef struct packed {
      logic        gig;
      logic [3:0]  n;
      logic [63:0] b;
      logic [8:0]  exp;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 4'd4, 64'h0000_0000_1312_1110, 9'h09B},
      '{1'b1, 4'd3, 64'h0000_0000_0022_5520, 9'h180},
      '{1'b0, 4'd7, 64'h0016_1514_1312_1110, 9'h0DB},
      '{1'b1, 4'd3, 64'h0000_0000_0012_9910, 9'h092},
      '{1'b0, 4'd2, 64'h0000_0000_0000_3130, 9'h080},
      '{1'b1, 4'd3, 64'h0000_0000_0032_3130, 9'h0A0},
      '{1'b0, 4'd1, 64'h0000_0000_0000_0010, 9'h010},
      '{1'b1, 4'd3, 64'h0000_0000_0022_2120, 9'h184}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // word = {last, mask, data}
   task automatic setp(input int p, input int i, input logic [7:0] d, input logic m, input logic l);
      pmem[p][i] = {l, m, d};
   endtask

   task automatic send_frame(input logic g, input int n, input logic [63:0] b);
      gig_mode = g;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = b[i*8 +: 8];
         if (!g) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
            repeat (2) @(negedge clk);
         end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); match_clr = 1'b1;
      @(negedge clk); match_clr = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NP; p++)
         for (int i = 0; i < ML; i++) pmem[p][i] = '0;
      setp(0,0,8'h10,0,0); setp(0,1,8'h11,0,0); setp(0,2,8'h12,0,1);
      setp(1,0,8'h10,0,0); setp(1,1,8'h00,1,0); setp(1,2,8'h12,0,1);
      setp(2,0,8'h20,0,0); setp(2,1,8'h21,0,1);
      setp(3,0,8'h10,0,0); setp(3,1,8'h11,0,0); setp(3,2,8'h12,0,0); setp(3,3,8'h13,0,1);
      setp(4,0,8'h10,0,1);
      setp(5,0,8'h30,0,0); setp(5,1,8'h31,0,0); setp(5,2,8'h32,0,1);
      for (int i = 0; i < 6; i++) setp(6, i, 8'h10 + 8'(i), 0, (i == 5));
      setp(7,0,8'h00,1,0); setp(7,1,8'h00,1,1);
      setp(8,0,8'h20,0,0); setp(8,1,8'h00,1,0); setp(8,2,8'h22,0,1);

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(match_q == '0, "R1 match after reset", 32'(match_q), 0);
      chk(wake == 1'b0, "R1 wake after reset", 32'(wake), 0);

      // R2: idle forwards and waits for enable
      rx_valid = 1'b1; rx_data = 8'h5A;
      #1;
      chk(rx_fwd_valid && rx_fwd_data == 8'h5A, "R2 idle forward", {rx_fwd_valid, rx_fwd_data}, 32'h15A);
      repeat (3) @(negedge clk);
      chk(rx_fwd_valid == 1'b1 && pat_rewind == 1'b0, "R2 still idle", {rx_fwd_valid, pat_rewind}, 2'b10);
      rx_valid = 1'b0;

      // R3: one initialise cycle, then forwarding stops
      pm_en = 1'b1;
      @(negedge clk);
      chk(pat_rewind == 1'b1, "R3 rewind pulse", 32'(pat_rewind), 1);
      @(negedge clk);
      chk(pat_rewind == 1'b0, "R3 rewind single cycle", 32'(pat_rewind), 0);
      rx_valid = 1'b1; rx_data = 8'h77; gig_mode = 1'b0;
      #1;
      chk(rx_fwd_valid == 1'b0, "R3 no forward while checking", 32'(rx_fwd_valid), 0);

      // R4: 10/100 group order for a stray byte (also R9)
      @(negedge clk); rx_valid = 1'b0;
      chk(pat_grp_rd == 3'b001, "R4 slot cycle 1", 32'(pat_grp_rd), 1);
      @(negedge clk);
      chk(pat_grp_rd == 3'b010, "R4 slot cycle 2", 32'(pat_grp_rd), 2);
      @(negedge clk);
      chk(pat_grp_rd == 3'b100, "R4 slot cycle 3", 32'(pat_grp_rd), 4);
      @(negedge clk);
      chk(pat_grp_rd == 3'b000, "R4 slot cycle 4 idle", 32'(pat_grp_rd), 0);

      // R5: gigabit parallel fetch
      gig_mode = 1'b1; rx_valid = 1'b1; rx_data = 8'h10;
      @(negedge clk); rx_valid = 1'b0;
      chk(pat_grp_rd == 3'b111, "R5 all groups at once", 32'(pat_grp_rd), 7);
      @(negedge clk);
      chk(pat_grp_rd == 3'b000, "R5 single cycle", 32'(pat_grp_rd), 0);
      repeat (4) @(negedge clk);
      chk(match_q == '0, "R9 stray bytes ignored", 32'(match_q), 0);

      // R6/R7/R8/R10/R11: table of frames
      for (int v = 0; v < 8; v++) begin
         send_frame(VEC[v].gig, int'(VEC[v].n), VEC[v].b);
         repeat (8) @(negedge clk);
         chk(match_q == VEC[v].exp, $sformatf("R6 R7 R8 vector %0d match", v), 32'(match_q), 32'(VEC[v].exp));
         chk(wake == 1'b1, $sformatf("R10 vector %0d wake", v), 32'(wake), 1);
         pulse_clr();
         @(negedge clk);
         chk(match_q == '0 && !wake, $sformatf("R11 vector %0d clear", v), {wake, 23'd0, match_q}, 0);
      end

      // R10: report ignores new traffic; R11: wake held
      send_frame(1'b0, 1, 64'h10);
      repeat (8) @(negedge clk);
      chk(match_q == 9'h010, "R8 single byte pattern", 32'(match_q), 32'h010);
      gig_mode = 1'b1; rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h20;
      #1;
      chk(rx_fwd_valid == 1'b0, "R10 no forward in report", 32'(rx_fwd_valid), 0);
      @(negedge clk); rx_sof = 1'b0; rx_data = 8'h21;
      @(negedge clk); rx_eof = 1'b1; rx_data = 8'h22;
      @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
      repeat (20) @(negedge clk);
      chk(match_q == 9'h010, "R10 report ignores frame", 32'(match_q), 32'h010);
      chk(wake == 1'b1, "R11 wake held", 32'(wake), 1);
      pulse_clr();
      @(negedge clk);
      chk(wake == 1'b0, "R11 wake after clear", 32'(wake), 0);

      // R12: enable drop keeps matches; re-enable clears them
      send_frame(1'b1, 3, 64'h222120);
      repeat (6) @(negedge clk);
      pm_en = 1'b0;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hC3;
      #1;
      chk(rx_fwd_valid && rx_fwd_data == 8'hC3, "R12 back to idle", {rx_fwd_valid, rx_fwd_data}, 32'h1C3);
      chk(match_q == 9'h184, "R12 match kept", 32'(match_q), 32'h184);
      @(negedge clk); rx_valid = 1'b0;
      pm_en = 1'b1;
      repeat (2) @(negedge clk);
      chk(match_q == '0 && !wake, "R3 initialise clears", 32'(match_q), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule